// File: doc/BRIEF.md
# Multi-Sample Serial Character Receiver

This block receives asynchronous serial characters: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A falling edge on the line starts a frame. Each bit is then sampled several times at evenly spaced instants. The spacing between samples is (divisor + 1) clock cycles, where the divisor is a 12-bit input. Normal mode takes four samples per bit and double-speed mode takes two. A frame is only clean if every sample of a bit agrees. Any disagreement, or a low stop bit, marks the character with a framing error. There is no majority vote.

A finished character goes into a holding buffer that is used only for reception. The buffer comes with a ready flag, an overrun flag and a framing-error flag. The error flags always describe the character currently held. If a new character finishes while the ready flag is still set, the new character is discarded, the held one is kept, and overrun is raised. A one-cycle read strobe clears the ready and overrun flags. An interrupt output follows the ready flag when its enable input is set. While receive is disabled, the line is ignored and any frame in progress is abandoned.

The controller has four states:
- `ST_IDLE` waits for a falling edge and moves to `ST_START`.
- `ST_START` returns to `ST_IDLE` as soon as any start sample reads high (a glitch). It moves to `ST_DATA` once all its samples have read low.
- `ST_DATA` moves to `ST_STOP` after the last sample of the eighth data bit.
- `ST_STOP` hands the character to the buffer on its last sample and returns to `ST_IDLE`.

Clearing the enable input forces `ST_IDLE` from any state.

Top module: `uart_msrx`

## Requirements
- R1: After reset, rx_ready, rx_overrun, rx_frame_err and rx_irq are all 0.
- R2: In normal mode (double_speed=0), a frame whose bits each last 4*(baud_div+1) clocks delivers its 8 data bits, least significant bit first, to rd_data and sets rx_ready.
- R3: In double-speed mode (double_speed=1), a frame whose bits each last 2*(baud_div+1) clocks is received in the same way.
- R4: If the samples of any data bit disagree, the character is still delivered, and rx_frame_err is set with it.
- R5: A stop bit that samples low sets rx_frame_err for the delivered character.
- R6: A low pulse on the line that does not hold low for every start-bit sample is dropped, and no character is delivered.
- R7: If a character finishes while rx_ready=1, rx_overrun is set, and rd_data and rx_frame_err keep the buffered character's values.
- R8: A one-cycle pulse on rd_strobe clears rx_ready and rx_overrun.
- R9: While rx_enable=0, activity on the line delivers no character.
- R10: rx_irq is 1 exactly when rx_ready=1 and irq_enable=1.
- R11: A clean character that is accepted into the buffer clears rx_frame_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| rx_enable | input | 1 | Receive enable |
| baud_div | input | 12 | Sample spacing minus one, in clocks |
| double_speed | input | 1 | 1 selects 2 samples per bit, 0 selects 4 |
| irq_enable | input | 1 | Enables the receive-complete interrupt |
| rd_strobe | input | 1 | Read pulse; clears the ready and overrun flags |
| rd_data | output | 8 | Buffered character |
| rx_ready | output | 1 | A character is waiting in the buffer |
| rx_overrun | output | 1 | A character was lost while the buffer was full |
| rx_frame_err | output | 1 | The buffered character had a framing error |
| rx_irq | output | 1 | Receive-complete interrupt |

## Verification
The bench builds the block with its default parameters: 8 data bits, a 12-bit divisor, 4 samples per bit in normal mode and 2 in double-speed mode. It runs with a divisor of 15, so each sample interval is 16 clocks. That spacing puts every sample well clear of the bit edges, even after the two-stage input synchroniser. It also allows a short inverted window to corrupt exactly one sample of a chosen bit, and allows start pulses shorter than the first sample point. With these settings the bench reaches single-sample disagreement, low stop bits, glitch rejection and overrun in both speed modes.

// File: rtl/uart_msrx_pkg.sv
package uart_msrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_msrx_sync.sv
module uart_msrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/uart_msrx_ticker.sv
module uart_msrx_ticker #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (restart)     cnt <= div >> 1;
        else if (cnt == '0)   cnt <= div;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0) && !restart;
endmodule

// File: rtl/uart_msrx_frame.sv
module uart_msrx_frame
    import uart_msrx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SPB_NORM = 4,
    parameter int SPB_FAST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx,
    input  logic              fall,
    input  logic              tick,
    input  logic              fast,
    output logic              restart,
    output logic              deliver,
    output logic [DATA_W-1:0] char_out,
    output logic              char_err
);
    localparam int SCNT_W = $clog2(SPB_NORM);
    localparam int BCNT_W = $clog2(DATA_W);

    rx_state_t         state, nxt;
    logic [SCNT_W-1:0] scnt;
    logic [BCNT_W-1:0] bcnt;
    logic              first, mism, err_acc;
    logic [DATA_W-1:0] shreg;
    logic [SCNT_W-1:0] spb_last;
    logic              last_sample, bit_bad;

    assign spb_last    = fast ? SCNT_W'(SPB_FAST - 1) : SCNT_W'(SPB_NORM - 1);
    assign last_sample = tick && (scnt >= spb_last);
    assign bit_bad     = mism || ((scnt != '0) && (rx != first));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and strobes
    always_comb begin
        nxt     = state;
        restart = 1'b0;
        deliver = 1'b0;
        if (!enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (fall) begin
                    nxt     = ST_START;
                    restart = 1'b1;
                end
                ST_START: begin
                    if (tick && rx)       nxt = ST_IDLE;
                    else if (last_sample) nxt = ST_DATA;
                end
                ST_DATA: if (last_sample && bcnt == BCNT_W'(DATA_W - 1)) nxt = ST_STOP;
                ST_STOP: if (last_sample) begin
                    nxt     = ST_IDLE;
                    deliver = 1'b1;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign char_out = shreg;
    assign char_err = err_acc | bit_bad | ~rx;

    // sample bookkeeping and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt    <= '0;
            bcnt    <= '0;
            first   <= 1'b1;
            mism    <= 1'b0;
            err_acc <= 1'b0;
            shreg   <= '0;
        end else if (restart) begin
            scnt    <= '0;
            bcnt    <= '0;
            mism    <= 1'b0;
            err_acc <= 1'b0;
        end else if (tick && state != ST_IDLE) begin
            if (scnt == '0)       first <= rx;
            else if (rx != first) mism  <= 1'b1;
            if (last_sample) begin
                scnt <= '0;
                mism <= 1'b0;
                if (state == ST_DATA) begin
                    shreg   <= {first, shreg[DATA_W-1:1]};
                    err_acc <= err_acc | bit_bad;
                    bcnt    <= bcnt + 1'b1;
                end
            end else begin
                scnt <= scnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_msrx_buffer.sv
module uart_msrx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic [DATA_W-1:0] char_in,
    input  logic              err_in,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              ovr,
    output logic              ferr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            ferr  <= 1'b0;
        end else if (deliver && (!ready || rd)) begin
            data  <= char_in;
            ready <= 1'b1;
            ovr   <= 1'b0;
            ferr  <= err_in;
        end else if (deliver) begin
            ovr <= 1'b1;
        end else if (rd) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_msrx.sv
module uart_msrx #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int SPB_NORM    = 4,
    parameter int SPB_FAST    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              rx_enable,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              double_speed,
    input  logic              irq_enable,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              rx_frame_err,
    output logic              rx_irq
);
    logic rx_s, rx_fall, restart, tick, deliver, char_err;
    logic [DATA_W-1:0] char_val;

    uart_msrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s), .fall(rx_fall)
    );

    uart_msrx_ticker #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(baud_div), .tick(tick)
    );

    uart_msrx_frame #(.DATA_W(DATA_W), .SPB_NORM(SPB_NORM), .SPB_FAST(SPB_FAST)) u_frame (
        .clk(clk), .rst_n(rst_n), .enable(rx_enable), .rx(rx_s), .fall(rx_fall),
        .tick(tick), .fast(double_speed), .restart(restart), .deliver(deliver),
        .char_out(char_val), .char_err(char_err)
    );

    uart_msrx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .deliver(deliver), .char_in(char_val),
        .err_in(char_err), .rd(rd_strobe), .data(rd_data), .ready(rx_ready),
        .ovr(rx_overrun), .ferr(rx_frame_err)
    );

    assign rx_irq = rx_ready & irq_enable;
endmodule

// File: rtl/uart_msrx_checker.sv
module uart_msrx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              irq_enable,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_ready,
    input logic              rx_overrun,
    input logic              rx_irq
);
    a_r8_read_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rx_overrun);

    a_r7_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe) |=> $stable(rd_data));

    a_r7_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_ready);

    a_r9_disabled_no_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rx_ready) |=> !rx_ready);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |-> !rx_irq);
endmodule

bind uart_msrx uart_msrx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .irq_enable(irq_enable),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rx_irq(rx_irq)
);

// File: tb/uart_msrx_bench.sv
module uart_msrx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b1;
    logic [11:0] baud_div = 12'd15;
    logic       double_speed = 1'b0;
    logic       irq_enable = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready, rx_overrun, rx_frame_err, rx_irq;

    int tests = 0;
    int fails = 0;
    bit quiet = 1'b0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_data = 8'h00;
    bit m_ready = 1'b0, m_ovr = 1'b0, m_ferr = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_msrx u_uart_msrx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
        .baud_div(baud_div), .double_speed(double_speed), .irq_enable(irq_enable),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err), .rx_irq(rx_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // per-clock comparison against the model while no frame is in flight
    always @(negedge clk) begin
        if (quiet && !finished) begin
            check("R2/R7 ready", rx_ready, m_ready);
            check("R7/R8 overrun", rx_overrun, m_ovr);
            check("R10 irq", rx_irq, m_ready && irq_enable);
            if (m_ready) begin
                check("R4/R5/R11 ferr", rx_frame_err, m_ferr);
                check("R2/R7 data", rd_data, m_data);
            end
        end
    end

    function automatic void model_accept(input logic [7:0] ch, input bit err);
        if (m_ready) m_ovr = 1'b1;
        else begin
            m_data = ch; m_ready = 1'b1; m_ovr = 1'b0; m_ferr = err;
        end
    endfunction

    // bad_bit: frame index 0..9 whose middle sample gets inverted (-1: none)
    task automatic send(input logic [7:0] ch, input bit stop_val, input int bad_bit);
        int p = (double_speed ? 2 : 4) * (int'(baud_div) + 1);
        quiet = 1'b0;
        for (int b = 0; b < 10; b++) begin
            logic v = (b == 0) ? 1'b0 : (b == 9) ? stop_val : ch[b-1];
            for (int j = 0; j < p; j++) begin
                @(negedge clk);
                rx_line = (b == bad_bit && j >= 22 && j < 34) ? ~v : v;
            end
        end
        @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        quiet = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read();
        quiet = 1'b0;
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m_ready = 1'b0; m_ovr = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", rx_ready, 0);
        check("R1 overrun", rx_overrun, 0);
        check("R1 ferr", rx_frame_err, 0);
        check("R1 irq", rx_irq, 0);
        settle();

        // R2 normal mode, R10 irq
        send(8'hA5, 1'b1, -1); model_accept(8'hA5, 0); settle();
        check("R2 data A5", rd_data, 8'hA5);
        check("R10 irq high", rx_irq, 1);
        do_read();
        check("R8 ready cleared", rx_ready, 0);

        // R3 double speed
        double_speed = 1'b1;
        send(8'h3C, 1'b1, -1); model_accept(8'h3C, 0); settle();
        check("R3 data 3C", rd_data, 8'h3C);
        check("R3 ferr", rx_frame_err, 0);
        do_read();

        // R4 disagreement inside data bit 3, double speed
        send(8'h5A, 1'b1, 4); model_accept(8'h5A, 1); settle();
        check("R4 ferr fast", rx_frame_err, 1);
        do_read();
        double_speed = 1'b0;

        // R4 normal mode
        send(8'hC3, 1'b1, 6); model_accept(8'hC3, 1); settle();
        check("R4 ferr", rx_frame_err, 1);
        check("R4 ready", rx_ready, 1);
        do_read();

        // R11 clean char clears error
        send(8'h81, 1'b1, -1); model_accept(8'h81, 0); settle();
        check("R11 ferr cleared", rx_frame_err, 0);
        do_read();

        // R5 low stop bit
        send(8'hFF, 1'b0, -1); model_accept(8'hFF, 1); settle();
        check("R5 ferr", rx_frame_err, 1);
        check("R5 data", rd_data, 8'hFF);
        do_read();

        // R6 glitch rejected
        quiet = 1'b0;
        @(negedge clk); rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        settle();
        check("R6 no char", rx_ready, 0);
        send(8'h42, 1'b1, -1); model_accept(8'h42, 0); settle();
        check("R6 next char", rd_data, 8'h42);

        // R7 overrun, held char kept
        send(8'h99, 1'b1, 3); model_accept(8'h99, 1); settle();
        check("R7 overrun", rx_overrun, 1);
        check("R7 data kept", rd_data, 8'h42);
        check("R7 ferr kept", rx_frame_err, 0);
        do_read();
        check("R8 overrun cleared", rx_overrun, 0);
        check("R8 ready cleared", rx_ready, 0);

        // R9 disabled receiver
        rx_enable = 1'b0;
        send(8'h77, 1'b1, -1); settle();
        check("R9 ignored", rx_ready, 0);
        rx_enable = 1'b1;
        settle();

        // R10 irq gated off, double speed
        irq_enable = 1'b0;
        double_speed = 1'b1;
        send(8'h12, 1'b1, -1); model_accept(8'h12, 0); settle();
        check("R10 irq off", rx_irq, 0);
        check("R3 data 12", rd_data, 8'h12);
        irq_enable = 1'b1;
        @(negedge clk);
        check("R10 irq on", rx_irq, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule